// File: doc/BRIEF.md
# Selectable-Convention Parity Encoder and Checker

This block adds and checks a single parity bit on short data words. A transmit stream takes a data word and emits a codeword one bit wider. The top bit of that codeword is the parity bit, and the data sits in the low bits. A receive stream takes a codeword and emits three things: the data bits, the modulo-2 sum of the bits that were received (the syndrome), and an error flag. One shared 3-bit mode input selects the parity convention for both streams:

| Code | Convention |
|---|---|
| 0 | none |
| 1 | even |
| 2 | odd |
| 3 | mark |
| 4 | space |
| 5 | ignore |

Codes 6 and 7 behave as ignore. The mode is sampled in the cycle a word is accepted.

Each stream is a valid/ready register slice with one cycle of latency. An input word is accepted on a clock edge where both in-valid and in-ready are high. In-ready is high whenever the output register is empty or its consumer is taking the current word in that same cycle. While out-valid is high and out-ready is low, the output holds its data unchanged and in-ready is low. The data width is a parameter, and the default is 7 data bits, which gives an 8-bit codeword with minimum distance 2.

Top module: `parity_codec`

## Requirements
- R1: In even mode the transmit codeword bit DW equals the XOR of the data bits, so the codeword has an even count of ones.
- R2: In odd mode the transmit codeword bit DW is the inverse of the XOR of the data bits, so the codeword has an odd count of ones.
- R3: In mark mode the transmitted bit DW is always 1. In space mode it is always 0, whatever the data.
- R4: In none mode no parity bit is sent: tx_out_par_en is 0, codeword bit DW is 0, rx_out_syndrome is the XOR of the received data bits only, and rx_out_err is 0.
- R5: In ignore mode, and for unused mode codes 6 and 7, the transmitter sends bit DW as 0 with tx_out_par_en at 1, and rx_out_err stays 0 whatever is received.
- R6: The receive path returns bits DW-1:0 of the codeword as rx_out_data. In every mode except none, rx_out_syndrome is the XOR of all DW+1 received bits.
- R7: The receive error flag follows the mode as follows. Even mode: the flag equals the syndrome. Odd mode: the flag equals the inverted syndrome. Mark mode: the flag is raised when the received bit DW is 0. Space mode: the flag is raised when the received bit DW is 1.
- R8: In even and odd modes, any odd number of flipped bits in a valid codeword raises rx_out_err, and any even number of flips leaves it low.
- R9: Each stream is a one-stage valid/ready slice. In-ready equals (not out-valid) or out-ready. An accepted word appears on the next cycle. An output that is not taken holds stable. If no word is accepted while the output can advance, out-valid falls.
- R10: A synchronous active-high reset clears every output register and flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Parity convention: 0 none, 1 even, 2 odd, 3 mark, 4 space, 5 ignore |
| tx_in_valid | input | 1 | Transmit data word valid |
| tx_in_ready | output | 1 | Transmit input can accept |
| tx_in_data | input | DW | Data word to encode |
| tx_out_valid | output | 1 | Codeword valid |
| tx_out_ready | input | 1 | Consumer takes codeword |
| tx_out_code | output | DW+1 | Codeword: bit DW is parity, bits DW-1:0 are data |
| tx_out_par_en | output | 1 | High when bit DW is part of the transmitted codeword |
| rx_in_valid | input | 1 | Received codeword valid |
| rx_in_ready | output | 1 | Receive input can accept |
| rx_in_code | input | DW+1 | Received codeword |
| rx_out_valid | output | 1 | Check result valid |
| rx_out_ready | input | 1 | Consumer takes result |
| rx_out_data | output | DW | Recovered data bits |
| rx_out_syndrome | output | 1 | XOR of the received bits |
| rx_out_err | output | 1 | Parity error detected |

## Verification
Both streams are due exactly one clock edge after a word is accepted. A word is accepted when valid and ready are both high at that edge. In-ready is combinational from out-ready and the slice state, so it is due in the same cycle. The bench keeps a behavioural model of each slice that is advanced by the same accept rule. It drives new inputs just after the falling edge, then compares every output, ready included, one time unit later, before the next rising edge. This means each comparison sees exactly the registers updated at the edge just passed. Random stalls on both the input and output sides exercise the hold case, and deliberately flipped received bits exercise the detection rule.

// File: rtl/parity_codec_pkg.sv
package parity_codec_pkg;

  typedef enum logic [2:0] {
    PM_NONE   = 3'd0,
    PM_EVEN   = 3'd1,
    PM_ODD    = 3'd2,
    PM_MARK   = 3'd3,
    PM_SPACE  = 3'd4,
    PM_IGNORE = 3'd5
  } pmode_e;

  // Unused codes fold onto the ignore convention.
  function automatic pmode_e pm_decode(input logic [2:0] raw);
    pmode_e m;
    case (raw)
      3'd0:    m = PM_NONE;
      3'd1:    m = PM_EVEN;
      3'd2:    m = PM_ODD;
      3'd3:    m = PM_MARK;
      3'd4:    m = PM_SPACE;
      default: m = PM_IGNORE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/parity_xor_tree.sv
// Linear XOR cascade over W bits.
module parity_xor_tree #(
  parameter int W = 7
) (
  input  logic [W-1:0] bits_i,
  output logic         par_o
);
  logic [W-1:0] chain;

  assign chain[0] = bits_i[0];
  generate
    for (genvar i = 1; i < W; i++) begin : g_link
      assign chain[i] = chain[i-1] ^ bits_i[i];
    end
  endgenerate

  assign par_o = chain[W-1];
endmodule

// File: rtl/parity_tx_enc.sv
module parity_tx_enc
  import parity_codec_pkg::*;
#(
  parameter int DW = 7,
  localparam int CW = DW + 1
) (
  input  logic [DW-1:0] data_i,
  input  logic [2:0]    mode_i,
  output logic [CW-1:0] code_o,
  output logic          par_en_o
);
  logic   dpar;
  logic   pbit;
  pmode_e m;

  parity_xor_tree #(.W(DW)) u_tree (.bits_i(data_i), .par_o(dpar));

  assign m = pm_decode(mode_i);

  always_comb begin
    pbit     = 1'b0;
    par_en_o = 1'b1;
    case (m)
      PM_NONE:  par_en_o = 1'b0;
      PM_EVEN:  pbit = dpar;
      PM_ODD:   pbit = ~dpar;
      PM_MARK:  pbit = 1'b1;
      PM_SPACE: pbit = 1'b0;
      default:  pbit = 1'b0;
    endcase
  end

  assign code_o = {pbit, data_i};
endmodule

// File: rtl/parity_rx_chk.sv
module parity_rx_chk
  import parity_codec_pkg::*;
#(
  parameter int DW = 7,
  localparam int CW = DW + 1
) (
  input  logic [CW-1:0] code_i,
  input  logic [2:0]    mode_i,
  output logic [DW-1:0] data_o,
  output logic          syn_o,
  output logic          err_o
);
  logic   dpar;
  logic   rbit;
  pmode_e m;

  parity_xor_tree #(.W(DW)) u_tree (.bits_i(code_i[DW-1:0]), .par_o(dpar));

  assign m      = pm_decode(mode_i);
  assign rbit   = code_i[DW];
  assign data_o = code_i[DW-1:0];

  always_comb begin
    syn_o = (m == PM_NONE) ? dpar : (dpar ^ rbit);
    case (m)
      PM_EVEN:  err_o = syn_o;
      PM_ODD:   err_o = ~syn_o;
      PM_MARK:  err_o = ~rbit;
      PM_SPACE: err_o = rbit;
      default:  err_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/parity_codec_stage.sv
// One-entry valid/ready register slice.
module parity_codec_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R9: stalled output holds
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: accepted word appears next cycle
  a_r9_accept_next: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  // R9: empty slot when nothing accepted
  a_r9_drain: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && in_ready) |=> !out_valid);
endmodule

// File: rtl/parity_codec.sv
module parity_codec
  import parity_codec_pkg::*;
#(
  parameter int DW = 7,
  localparam int CW = DW + 1,
  localparam int RW = DW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    mode,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [CW-1:0] tx_out_code,
  output logic          tx_out_par_en,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [CW-1:0] rx_in_code,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  output logic          rx_out_syndrome,
  output logic          rx_out_err
);
  // Transmit path
  logic [CW-1:0] enc_code;
  logic          enc_par_en;
  logic [CW:0]   tx_pay;

  parity_tx_enc #(.DW(DW)) u_enc (
    .data_i   (tx_in_data),
    .mode_i   (mode),
    .code_o   (enc_code),
    .par_en_o (enc_par_en)
  );

  parity_codec_stage #(.W(CW + 1)) u_tx_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   ({enc_par_en, enc_code}),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_pay)
  );

  assign tx_out_par_en = tx_pay[CW];
  assign tx_out_code   = tx_pay[CW-1:0];

  // Receive path
  logic [DW-1:0] chk_data;
  logic          chk_syn;
  logic          chk_err;
  logic [RW-1:0] rx_pay;

  parity_rx_chk #(.DW(DW)) u_chk (
    .code_i (rx_in_code),
    .mode_i (mode),
    .data_o (chk_data),
    .syn_o  (chk_syn),
    .err_o  (chk_err)
  );

  parity_codec_stage #(.W(RW)) u_rx_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   ({chk_err, chk_syn, chk_data}),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_pay)
  );

  assign rx_out_err      = rx_pay[RW-1];
  assign rx_out_syndrome = rx_pay[RW-2];
  assign rx_out_data     = rx_pay[DW-1:0];

  // R1: even codeword has even weight
  a_r1_even_weight: assert property (@(posedge clk) disable iff (rst)
    (tx_in_valid && mode == 3'd1) |-> ((^enc_code) == 1'b0));

  // R2: odd codeword has odd weight
  a_r2_odd_weight: assert property (@(posedge clk) disable iff (rst)
    (tx_in_valid && mode == 3'd2) |-> ((^enc_code) == 1'b1));

  // R3: mark and space constants
  a_r3_mark_space: assert property (@(posedge clk) disable iff (rst)
    (tx_in_valid && (mode == 3'd3 || mode == 3'd4)) |-> (enc_code[DW] == (mode == 3'd3)));

  // R4: nothing sent in none mode
  a_r4_none_bare: assert property (@(posedge clk) disable iff (rst)
    (tx_in_valid && mode == 3'd0) |-> (!enc_par_en && !enc_code[DW]));

  // R5: no error in ignore or unused codes
  a_r5_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
    (rx_in_valid && mode >= 3'd5) |-> !chk_err);

  // R10: reset leaves both slices empty
  a_r10_reset_empty: assert property (@(posedge clk)
    rst |=> (!tx_out_valid && !rx_out_valid && !rx_out_err));
endmodule

// File: tb/tb_parity_codec.sv
module tb_parity_codec;
  localparam int DW = 7;
  localparam int CW = DW + 1;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    mode;
  logic          tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready, tx_out_par_en;
  logic [DW-1:0] tx_in_data;
  logic [CW-1:0] tx_out_code;
  logic          rx_in_valid, rx_in_ready, rx_out_valid, rx_out_ready;
  logic          rx_out_syndrome, rx_out_err;
  logic [CW-1:0] rx_in_code;
  logic [DW-1:0] rx_out_data;

  parity_codec #(.DW(DW)) dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model state: current and pending (after next edge)
  bit            m_tv, p_tv, m_rv, p_rv;
  bit [CW-1:0]   m_tc, p_tc;
  bit            m_tpe, p_tpe;
  bit [DW-1:0]   m_rd, p_rd;
  bit            m_rs, p_rs, m_re, p_re;
  string         m_ttag, p_ttag, m_rtag, p_rtag;

  function automatic bit bpar(input bit [CW-1:0] v);
    return ($countones(v) % 2) == 1;
  endfunction

  function automatic string tx_tag(input int md);
    case (md)
      0: return "R4";
      1: return "R1";
      2: return "R2";
      3, 4: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural encode: returns {par_en, code}
  function automatic bit [CW:0] ref_enc(input bit [DW-1:0] d, input int md);
    bit p = bpar({1'b0, d});
    case (md)
      0: return {1'b0, 1'b0, d};
      1: return {1'b1, p, d};
      2: return {1'b1, ~p, d};
      3: return {1'b1, 1'b1, d};
      4: return {1'b1, 1'b0, d};
      default: return {1'b1, 1'b0, d};
    endcase
  endfunction

  task automatic compare_all();
    chk("R9 tx_in_ready", tx_in_ready, !m_tv || tx_out_ready);
    chk("R9 rx_in_ready", rx_in_ready, !m_rv || rx_out_ready);
    chk("R9 tx_out_valid", tx_out_valid, m_tv);
    chk("R9 rx_out_valid", rx_out_valid, m_rv);
    if (m_tv) begin
      chk({m_ttag, " tx_out_code"}, tx_out_code, m_tc);
      chk({m_ttag, " tx_out_par_en"}, tx_out_par_en, m_tpe);
    end
    if (m_rv) begin
      chk("R6 rx_out_data", rx_out_data, m_rd);
      chk({m_rtag, " rx_out_syndrome"}, rx_out_syndrome, m_rs);
      chk({m_rtag, " rx_out_err"}, rx_out_err, m_re);
    end
  endtask

  task automatic compute_pending(input int flips);
    int md = int'(mode);
    if (rst) begin
      p_tv = 0; p_rv = 0; p_tc = '0; p_tpe = 0; p_rd = '0; p_rs = 0; p_re = 0;
      return;
    end
    p_tv = m_tv; p_tc = m_tc; p_tpe = m_tpe; p_ttag = m_ttag;
    p_rv = m_rv; p_rd = m_rd; p_rs = m_rs; p_re = m_re; p_rtag = m_rtag;
    if (!m_tv || tx_out_ready) begin
      p_tv = tx_in_valid;
      if (tx_in_valid) begin
        bit [CW:0] e = ref_enc(tx_in_data, md);
        p_tpe = e[CW]; p_tc = e[CW-1:0]; p_ttag = tx_tag(md);
      end
    end
    if (!m_rv || rx_out_ready) begin
      p_rv = rx_in_valid;
      if (rx_in_valid) begin
        bit s;
        p_rd = rx_in_code[DW-1:0];
        s = (md == 0) ? bpar({1'b0, rx_in_code[DW-1:0]}) : bpar(rx_in_code);
        p_rs = s;
        case (md)
          1: p_re = s;
          2: p_re = ~s;
          3: p_re = ~rx_in_code[DW];
          4: p_re = rx_in_code[DW];
          default: p_re = 1'b0;
        endcase
        if (md == 0 || md >= 5) p_rtag = (md == 0) ? "R4" : "R5";
        else if (md <= 2) p_rtag = (flips > 0) ? "R8" : "R7";
        else p_rtag = "R7";
      end
    end
  endtask

  task automatic apply_pending();
    m_tv = p_tv; m_tc = p_tc; m_tpe = p_tpe; m_ttag = p_ttag;
    m_rv = p_rv; m_rd = p_rd; m_rs = p_rs; m_re = p_re; m_rtag = p_rtag;
  endtask

  // One cycle: apply model, drive, compare, predict.
  task automatic cycle(input bit r, input int md, input int pstall);
    int flips = 0;
    @(negedge clk);
    apply_pending();
    rst          = r;
    mode         = 3'(md);
    tx_in_valid  = ($urandom % 4) != 0;
    tx_in_data   = DW'($urandom);
    tx_out_ready = ($urandom % 100) >= pstall;
    rx_in_valid  = ($urandom % 4) != 0;
    rx_out_ready = ($urandom % 100) >= pstall;
    begin
      bit [CW:0] e = ref_enc(DW'($urandom), (md >= 5) ? 1 : md);
      bit [CW-1:0] c = e[CW-1:0];
      flips = $urandom % 4;
      for (int f = 0; f < flips; f++) c[(f * 3 + md) % CW] ^= 1'b1;
      if (md >= 5) c = CW'($urandom);
      rx_in_code = c;
    end
    #1;
    if (!r) compare_all();
    compute_pending(flips);
  endtask

  initial begin
    rst = 1'b1; mode = '0;
    tx_in_valid = 0; tx_in_data = '0; tx_out_ready = 0;
    rx_in_valid = 0; rx_in_code = '0; rx_out_ready = 0;
    m_ttag = "R1"; m_rtag = "R7"; p_ttag = "R1"; p_rtag = "R7";
    p_tv = 0; p_rv = 0; p_tc = '0; p_tpe = 0; p_rd = '0; p_rs = 0; p_re = 0;
    repeat (3) cycle(1'b1, 0, 0);
    // R10: reset state
    @(negedge clk); apply_pending();
    rst = 1'b0; tx_in_valid = 0; rx_in_valid = 0; #1;
    chk("R10 tx_out_valid", tx_out_valid, 0);
    chk("R10 rx_out_valid", rx_out_valid, 0);
    chk("R10 tx_out_code", tx_out_code, 0);
    chk("R10 rx_out_err", rx_out_err, 0);
    chk("R10 rx_out_syndrome", rx_out_syndrome, 0);
    compute_pending(0);
    // every mode code, free-flowing then stalled
    for (int md = 0; md < 8; md++) begin
      for (int k = 0; k < 150; k++) cycle(1'b0, md, 0);
      for (int k = 0; k < 150; k++) cycle(1'b0, md, 60);
    end
    // mid-run reset
    cycle(1'b1, 1, 50);
    cycle(1'b0, 1, 0);
    for (int k = 0; k < 400; k++) cycle(1'b0, $urandom % 8, 30);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule